// File: doc/BRIEF.md
# Two-Road Traffic Light Controller

This block drives the lamps of a crossing where two roads meet, north-south and east-west. Each road has only a green lamp and a red lamp, and exactly one road shows green at any time. Each road has a car detector, and the controller decides which road gets green based on those detectors. It does not react at once. An interval timer divides the system clock into fixed update instants, 30 seconds apart in the field. The detectors are read only at those instants.

The controller has two named states, `ROAD_NS` (north-south green) and `ROAD_EW` (east-west green). There are four named transitions, each taken on an update instant:
- `NS_HOLD`: stay in `ROAD_NS` because no car waits east-west.
- `NS_TO_EW`: move to `ROAD_EW` because a car waits east-west.
- `EW_HOLD`: stay in `ROAD_EW` because no car waits north-south.
- `EW_TO_NS`: move to `ROAD_NS` because a car waits north-south.

A road keeps green while nobody waits on the other road. The lamp outputs are decoded from the current state alone. In simulation the parameter `TICKS` is set to a small number of cycles.

Top module: `two_road_signal`

## Requirements
- R1: While `rst` is high at a rising clock edge, the state becomes `ROAD_NS` and the interval counter clears. After `rst` is released, the first update instant is the `TICKS`-th rising edge after the last reset edge.
- R2: `green_ns` and `green_ew` are never both high or both low after reset. `red_ns` is always the inverse of `green_ns`, and `red_ew` is always the inverse of `green_ew`.
- R3: In `ROAD_NS`, if `car_ew` is 1 at an update instant, the next state is `ROAD_EW`, whatever `car_ns` shows (`NS_TO_EW`).
- R4: In `ROAD_NS`, if `car_ew` is 0 at an update instant, the state stays `ROAD_NS`, even when `car_ns` is 1 (`NS_HOLD`).
- R5: In `ROAD_EW`, if `car_ns` is 1 at an update instant, the next state is `ROAD_NS`, whatever `car_ew` shows (`EW_TO_NS`).
- R6: In `ROAD_EW`, if `car_ns` is 0 at an update instant, the state stays `ROAD_EW`, even when `car_ew` is 1 (`EW_HOLD`).
- R7: Update instants recur every `TICKS` clock cycles. The lamps can change only on the edge that closes an update interval.
- R8: Detector values present in any cycle other than an update instant have no effect on the state or the lamps.
- R9: A reset applied mid-interval, or in the very cycle of an update instant, returns the lamps to north-south green and restarts the interval. A reset wins over a pending transition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| car_ns | input | 1 | North-south car detector, 1 = car waiting |
| car_ew | input | 1 | East-west car detector, 1 = car waiting |
| green_ns | output | 1 | North-south green lamp drive |
| red_ns | output | 1 | North-south red lamp drive |
| green_ew | output | 1 | East-west green lamp drive |
| red_ew | output | 1 | East-west red lamp drive |

## Verification
Two functions can fall in the same cycle: reset, and an update instant that would otherwise take a transition. The bench provokes this in `ROAD_NS`. It lets the interval run to its last cycle, then raises `car_ew` and `rst` together at that cycle. The lamps must stay north-south green, and the next transition must arrive exactly `TICKS` edges after that reset. The second case is detector activity in every non-update cycle. The bench toggles both detectors in those cycles and judges them by per-cycle lamp comparison against the scoreboard's expected state.

// File: rtl/tlc_pkg.sv
package tlc_pkg;

    typedef enum logic {
        ROAD_NS = 1'b0,
        ROAD_EW = 1'b1
    } road_t;

endpackage

// File: rtl/interval_tick.sv
module interval_tick #(
    parameter int TICKS = 1_500_000_000
) (
    input  logic clk,
    input  logic rst,
    output logic strobe
);

    localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    generate
        if (TICKS > 1) begin : g_counter
            logic [CW-1:0] count;

            always_ff @(posedge clk) begin
                if (rst) begin
                    count <= '0;
                end else if (count == LAST) begin
                    count <= '0;
                end else begin
                    count <= count + 1'b1;
                end
            end

            assign strobe = (count == LAST) && !rst;

            // R7: after a strobe the counter wraps, so the next cycle is quiet
            a_r7_strobe_gap: assert property (@(posedge clk) disable iff (rst)
                strobe |=> !strobe);

            // R1: a reset edge leaves the counter at zero
            a_r1_count_clear: assert property (@(posedge clk)
                rst |=> (count == '0));
        end else begin : g_every_cycle
            assign strobe = !rst;
        end
    endgenerate

endmodule

// File: rtl/road_select_fsm.sv
module road_select_fsm
    import tlc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  strobe,
    input  logic  car_ns,
    input  logic  car_ew,
    output road_t state
);

    road_t next_state;

    // next-state function: detectors matter only on an update strobe
    always_comb begin
        next_state = state;
        if (strobe) begin
            unique case (state)
                ROAD_NS: next_state = car_ew ? ROAD_EW : ROAD_NS;  // NS_TO_EW / NS_HOLD
                ROAD_EW: next_state = car_ns ? ROAD_NS : ROAD_EW;  // EW_TO_NS / EW_HOLD
                default: next_state = ROAD_NS;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ROAD_NS;
        end else begin
            state <= next_state;
        end
    end

    a_r1_reset_ns: assert property (@(posedge clk)
        rst |=> (state == ROAD_NS));

    a_r3_ns_to_ew: assert property (@(posedge clk) disable iff (rst)
        (strobe && state == ROAD_NS && car_ew) |=> (state == ROAD_EW));

    a_r4_ns_hold: assert property (@(posedge clk) disable iff (rst)
        (strobe && state == ROAD_NS && !car_ew) |=> (state == ROAD_NS));

    a_r5_ew_to_ns: assert property (@(posedge clk) disable iff (rst)
        (strobe && state == ROAD_EW && car_ns) |=> (state == ROAD_NS));

    a_r6_ew_hold: assert property (@(posedge clk) disable iff (rst)
        (strobe && state == ROAD_EW && !car_ns) |=> (state == ROAD_EW));

    a_r8_quiet_hold: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> $stable(state));

endmodule

// File: rtl/lamp_decode.sv
module lamp_decode
    import tlc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  road_t state,
    output logic  green_ns,
    output logic  red_ns,
    output logic  green_ew,
    output logic  red_ew
);

    // output function of the current state only
    always_comb begin
        unique case (state)
            ROAD_NS: begin
                green_ns = 1'b1;
                green_ew = 1'b0;
            end
            ROAD_EW: begin
                green_ns = 1'b0;
                green_ew = 1'b1;
            end
            default: begin
                green_ns = 1'b1;
                green_ew = 1'b0;
            end
        endcase
        red_ns = ~green_ns;
        red_ew = ~green_ew;
    end

    a_r2_one_green: assert property (@(posedge clk) disable iff (rst)
        $countones({green_ns, green_ew}) == 1);

    a_r2_red_pairs: assert property (@(posedge clk) disable iff (rst)
        (red_ns != green_ns) && (red_ew != green_ew) && (red_ns != red_ew));

endmodule

// File: rtl/two_road_signal.sv
module two_road_signal
    import tlc_pkg::*;
#(
    parameter int TICKS = 1_500_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic car_ns,
    input  logic car_ew,
    output logic green_ns,
    output logic red_ns,
    output logic green_ew,
    output logic red_ew
);

    logic  update;
    road_t cur_road;

    interval_tick #(.TICKS(TICKS)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .strobe (update)
    );

    road_select_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .strobe (update),
        .car_ns (car_ns),
        .car_ew (car_ew),
        .state  (cur_road)
    );

    lamp_decode u_lamps (
        .clk      (clk),
        .rst      (rst),
        .state    (cur_road),
        .green_ns (green_ns),
        .red_ns   (red_ns),
        .green_ew (green_ew),
        .red_ew   (red_ew)
    );

    // R7: lamps change only on the edge that follows an update strobe
    a_r7_change_on_update: assert property (@(posedge clk) disable iff (rst)
        !update |=> $stable(green_ew));

endmodule

// File: tb/two_road_signal_test.sv
module two_road_signal_test;

    localparam int TICKS = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic car_ns = 1'b0;
    logic car_ew = 1'b0;
    logic green_ns, red_ns, green_ew, red_ew;

    int checks = 0;
    int errors = 0;
    bit mon_on = 1'b0;
    bit done = 1'b0;

    // scoreboard: expected east-west-green flag after each update, with its tag
    bit    exp_q[$];
    string tag_q[$];
    bit    mdl_ew = 1'b0;

    always #5 clk = ~clk;

    two_road_signal #(.TICKS(TICKS)) uut (
        .clk      (clk),
        .rst      (rst),
        .car_ns   (car_ns),
        .car_ew   (car_ew),
        .green_ns (green_ns),
        .red_ns   (red_ns),
        .green_ew (green_ew),
        .red_ew   (red_ew)
    );

    task automatic check(input string tag, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // driver tasks: called at a falling edge, leave at a falling edge
    task automatic apply_reset();
        rst = 1'b1;
        mdl_ew = 1'b0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic noise(input int i);
        car_ns = 1'((i >> 0) & 1);
        car_ew = 1'(~(i >> 1) & 1);
    endtask

    task automatic run_interval(input bit ns_at, input bit ew_at, input string tag);
        for (int i = 0; i < TICKS; i++) begin
            if (i == TICKS - 1) begin
                car_ns = ns_at;
                car_ew = ew_at;
                mdl_ew = mdl_ew ? !ns_at : ew_at;
                exp_q.push_back(mdl_ew);
                tag_q.push_back(tag);
            end else begin
                noise(i);
            end
            @(negedge clk);
        end
    endtask

    task automatic run_partial(input int n);
        for (int i = 0; i < n; i++) begin
            noise(i + 1);
            @(negedge clk);
        end
    endtask

    // monitor: samples 2 ns after each rising edge
    int    cyc = 0;
    bit    exp_ew = 1'b0;
    string cur_tag = "R1";

    always begin
        @(posedge clk);
        #2;
        if (mon_on && !done) begin
            if (rst) begin
                cyc = 0;
                exp_ew = 1'b0;
                cur_tag = "R1 R9";
            end else begin
                cyc++;
                if (cyc == TICKS) begin
                    cyc = 0;
                    if (exp_q.size() == 0) begin
                        checks++;
                        errors++;
                        $display("FAIL R7 scoreboard empty at update: actual=none expected=item");
                    end else begin
                        exp_ew = exp_q.pop_front();
                        cur_tag = tag_q.pop_front();
                    end
                end else begin
                    cur_tag = "R7 R8";
                end
            end
            check(cur_tag, green_ew, exp_ew, "green_ew");
            check(cur_tag, green_ns, !exp_ew, "green_ns");
            check("R2", red_ns, ~green_ns, "red_ns");
            check("R2", red_ew, ~green_ew, "red_ew");
        end
    end

    initial begin
        @(posedge clk);
        mon_on = 1'b1;
        @(negedge clk);
        @(negedge clk);
        apply_reset();
        run_interval(1'b0, 1'b0, "R4");       // NS_HOLD, no cars
        run_interval(1'b1, 1'b0, "R4");       // NS_HOLD, car only on green road
        run_interval(1'b0, 1'b1, "R3");       // NS_TO_EW
        run_interval(1'b0, 1'b1, "R6");       // EW_HOLD, car only on green road
        run_interval(1'b0, 1'b0, "R6");       // EW_HOLD, no cars
        run_interval(1'b1, 1'b1, "R5");       // EW_TO_NS, both waiting
        run_interval(1'b1, 1'b1, "R3");       // NS_TO_EW, both waiting
        run_interval(1'b1, 1'b0, "R5");       // EW_TO_NS
        run_interval(1'b0, 1'b1, "R3");       // to EW before mid-interval reset
        run_partial(3);
        apply_reset();                        // R9 mid-interval
        run_interval(1'b0, 1'b0, "R1");       // interval restarted from zero
        run_partial(TICKS - 1);
        car_ew = 1'b1;                        // R9: reset coincides with update strobe
        car_ns = 1'b0;
        apply_reset();
        run_interval(1'b0, 1'b1, "R1");       // first update exactly TICKS edges later
        run_interval(1'b1, 1'b1, "R5");
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200_000 * 10);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule